// File: doc/BRIEF.md
# UART Channel Mode and FIFO Steering

This block owns the receive and transmit byte queues of a serial port and decides where each byte goes. A host writes a control word that holds self-clearing queue flushes, a separate enable and disable bit for each direction, a timeout restart and a break request pair. A two-bit channel mode field selects one of four routings. Bytes from the line receiver and bytes written by the host are steered into the receive queue, the transmit queue, both, or neither. The transmit queue is drained by a serialiser through a valid/ready handshake. The host pops the receive queue through a read port.

A receive timeout state machine watches the receive queue. It has three states. `TMO_IDLE` waits for a byte. On any byte accepted into the receive queue it moves to `TMO_COUNT`. `TMO_COUNT` counts baud ticks, reloads on each new byte or on a restart command, and returns to `TMO_IDLE` on a receive flush. When the count reaches four character times it moves to `TMO_FIRE`. `TMO_FIRE` lasts one cycle and drives the timeout event. From there the machine goes to `TMO_COUNT` if a byte arrives in that cycle, and otherwise back to `TMO_IDLE`.

Overrun events are registered one cycle after the rejected byte. All events are single-cycle pulses meant for a separate interrupt block.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset the control word reads 0x128. Both directions are inactive, and both queues are empty.
- R2: Writing the control word with bit 0 set empties the receive queue, and with bit 1 set empties the transmit queue, by the next cycle. Both bits always read back as 0, and a flush wins over a push in the same cycle.
- R3: The receive path is active only when bit 2 (enable) is 1 and bit 3 (disable) is 0. The transmit path is active only when bit 4 is 1 and bit 5 is 0. While a path is inactive, pushes into its queue and host reads from it leave the level unchanged, and a read returns 0.
- R4: The mode field (mode register bits 9:8) takes 0 for normal, 1 for echo, 2 for local loopback and 3 for remote loopback. A line byte enters the receive queue in normal and echo modes, and enters the transmit queue in echo and remote loopback modes.
- R5: A host data write enters the transmit queue in normal mode and the receive queue in local loopback mode. In echo and remote loopback modes it is dropped.
- R6: A byte steered to a full receive queue is discarded, and `evt_rx_ovr` pulses for one cycle in the following cycle. If a host read pops the queue in the same cycle, the byte is accepted and no overrun is raised.
- R7: A byte steered to a full transmit queue is discarded, and `evt_tx_ovr` pulses in the following cycle.
- R8: `host_rd_data` is 0 whenever the receive queue is empty.
- R9: `break_req` is 1 exactly when control bit 7 (start break) is 1 and bit 8 (stop break) is 0.
- R10: When `tmo_val` is nonzero, `evt_rx_tmo` pulses for one cycle, in the cycle after the 4×`char_ticks`-th baud tick that follows the last byte accepted into the receive queue. When `tmo_val` is 0 it never pulses.
- R11: Each byte accepted into the receive queue restarts the timeout count. A control write with bit 6 set also restarts it.
- R12: Both queues are first-in first-out. `tx_valid` is high whenever the transmit queue is not empty, and a byte is removed on a cycle with `tx_valid` and `tx_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 9 | Control word write value |
| ctl_rd_data | output | 9 | Control word readback |
| mode_wr_en | input | 1 | Mode field write strobe |
| mode_wr_field | input | 2 | Mode field value (mode register bits 9:8) |
| tmo_val | input | TMO_W (8) | Timeout setting; 0 disables the timeout |
| char_ticks | input | TICK_W (8) | Baud ticks per character |
| baud_tick | input | 1 | One-cycle baud tick |
| host_wr_en | input | 1 | Host data write strobe |
| host_wr_data | input | DATA_W (8) | Host data write byte |
| host_rd_en | input | 1 | Host data read strobe (pops on this cycle) |
| host_rd_data | output | DATA_W (8) | Head of the receive queue, or 0 |
| line_rx_valid | input | 1 | Byte strobe from the line receiver |
| line_rx_data | input | DATA_W (8) | Byte from the line receiver |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | DATA_W (8) | Head of the transmit queue |
| tx_ready | input | 1 | Serialiser takes the byte |
| break_req | output | 1 | Break requested on the line |
| rx_level | output | $clog2(DEPTH+1) (5) | Receive queue fill level |
| tx_level | output | $clog2(DEPTH+1) (5) | Transmit queue fill level |
| evt_rx_ovr | output | 1 | Receive overrun pulse |
| evt_tx_ovr | output | 1 | Transmit overflow pulse |
| evt_rx_tmo | output | 1 | Receive timeout pulse |

## Verification
A host read that pops the receive queue can land in the same cycle as a line byte that pushes into it. The bench provokes this on a completely full queue. A correct design takes the new byte without an overrun, keeps the level at the full depth, and presents the new byte last when the queue is read out. A second collision is between a control write that restarts the timeout and a pending count. The bench judges it by counting timeout pulses after a known number of baud ticks.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL    = 2'd0,
        CH_ECHO      = 2'd1,
        CH_LOCAL_LB  = 2'd2,
        CH_REMOTE_LB = 2'd3
    } chan_mode_e;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRE  = 2'd2
    } tmo_state_e;

    localparam int CTL_W      = 9;
    localparam int CB_RX_RST  = 0;
    localparam int CB_TX_RST  = 1;
    localparam int CB_RX_EN   = 2;
    localparam int CB_RX_DIS  = 3;
    localparam int CB_TX_EN   = 4;
    localparam int CB_TX_DIS  = 5;
    localparam int CB_TMO_RST = 6;
    localparam int CB_BRK_ON  = 7;
    localparam int CB_BRK_OFF = 8;

    localparam logic [CTL_W-1:0] CTL_RESET = 9'h128;

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rptr_q;
    logic [AW-1:0]     wptr_q;
    logic [CW-1:0]     count_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            wptr_q  <= '0;
            count_q <= '0;
        end else if (flush) begin
            rptr_q  <= '0;
            wptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                wptr_q <= ptr_inc(wptr_q);
            end
            if (pop) begin
                rptr_q <= ptr_inc(rptr_q);
            end
            unique case ({push, pop})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    always_comb begin
        rdata = mem[rptr_q];
        count = count_q;
        full  = (count_q == CW'(DEPTH));
        empty = (count_q == '0);
    end

endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
    import uart_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    input  logic             mode_wr_en,
    input  logic [1:0]       mode_wr_field,
    output logic [CTL_W-1:0] ctl_q,
    output chan_mode_e       mode,
    output logic             rx_active,
    output logic             tx_active,
    output logic             break_req,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             tmo_restart
);

    logic [CTL_W-1:0] ctl_r;
    chan_mode_e       mode_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_r <= CTL_RESET;
        end else if (ctl_wr_en) begin
            // flush bits act once and are never stored
            ctl_r <= {ctl_wr_data[CTL_W-1:2], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r <= CH_NORMAL;
        end else if (mode_wr_en) begin
            mode_r <= chan_mode_e'(mode_wr_field);
        end
    end

    always_comb begin
        ctl_q       = ctl_r;
        mode        = mode_r;
        rx_active   = ctl_r[CB_RX_EN] & ~ctl_r[CB_RX_DIS];
        tx_active   = ctl_r[CB_TX_EN] & ~ctl_r[CB_TX_DIS];
        break_req   = ctl_r[CB_BRK_ON] & ~ctl_r[CB_BRK_OFF];
        rx_flush    = ctl_wr_en & ctl_wr_data[CB_RX_RST];
        tx_flush    = ctl_wr_en & ctl_wr_data[CB_TX_RST];
        tmo_restart = ctl_wr_en & ctl_wr_data[CB_TMO_RST];
    end

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
    import uart_chan_pkg::*;
#(
    parameter int TICK_W = 8,
    parameter int TMO_W  = 8,
    localparam int CNT_W = TICK_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_push,
    input  logic              rx_flush,
    input  logic              restart,
    input  logic [TMO_W-1:0]  tmo_val,
    input  logic              baud_tick,
    input  logic [TICK_W-1:0] char_ticks,
    output logic              evt_tmo
);

    tmo_state_e       state_q;
    tmo_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             tmo_on;
    logic             at_limit;

    always_comb begin
        limit    = {char_ticks, 2'b00};
        tmo_on   = (tmo_val != '0);
        at_limit = (cnt_q == limit - CNT_W'(1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMO_IDLE: begin
                if (rx_push && !rx_flush) begin
                    state_d = TMO_COUNT;
                end
            end
            TMO_COUNT: begin
                if (rx_flush) begin
                    state_d = TMO_IDLE;
                end else if (rx_push || restart) begin
                    state_d = TMO_COUNT;
                end else if (tmo_on && baud_tick && at_limit) begin
                    state_d = TMO_FIRE;
                end
            end
            TMO_FIRE: begin
                state_d = (rx_push && !rx_flush) ? TMO_COUNT : TMO_IDLE;
            end
            default: state_d = TMO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != TMO_COUNT || rx_push || restart) begin
            cnt_q <= '0;
        end else if (tmo_on && baud_tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        evt_tmo = (state_q == TMO_FIRE);
    end

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
    import uart_chan_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int TICK_W = 8,
    parameter int TMO_W  = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [8:0]        ctl_wr_data,
    output logic [8:0]        ctl_rd_data,
    input  logic              mode_wr_en,
    input  logic [1:0]        mode_wr_field,
    input  logic [TMO_W-1:0]  tmo_val,
    input  logic [TICK_W-1:0] char_ticks,
    input  logic              baud_tick,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              host_rd_en,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              line_rx_valid,
    input  logic [DATA_W-1:0] line_rx_data,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              break_req,
    output logic [LVL_W-1:0]  rx_level,
    output logic [LVL_W-1:0]  tx_level,
    output logic              evt_rx_ovr,
    output logic              evt_tx_ovr,
    output logic              evt_rx_tmo
);

    chan_mode_e        mode;
    logic              rx_active, tx_active;
    logic              rx_flush, tx_flush, tmo_restart;
    logic              line_to_rx, line_to_tx, host_to_rx, host_to_tx;
    logic              rx_req, tx_req;
    logic              rx_push, rx_pop, tx_push, tx_pop;
    logic              rx_full, rx_empty, tx_full, tx_empty;
    logic              rx_ovr_d, tx_ovr_d;
    logic [DATA_W-1:0] rx_wdata, tx_wdata, rx_head, tx_head;

    uart_chan_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_wr_en     (ctl_wr_en),
        .ctl_wr_data   (ctl_wr_data),
        .mode_wr_en    (mode_wr_en),
        .mode_wr_field (mode_wr_field),
        .ctl_q         (ctl_rd_data),
        .mode          (mode),
        .rx_active     (rx_active),
        .tx_active     (tx_active),
        .break_req     (break_req),
        .rx_flush      (rx_flush),
        .tx_flush      (tx_flush),
        .tmo_restart   (tmo_restart)
    );

    // routing of each byte source by channel mode
    always_comb begin
        line_to_rx = line_rx_valid && (mode == CH_NORMAL || mode == CH_ECHO);
        line_to_tx = line_rx_valid && (mode == CH_ECHO || mode == CH_REMOTE_LB);
        host_to_tx = host_wr_en && (mode == CH_NORMAL);
        host_to_rx = host_wr_en && (mode == CH_LOCAL_LB);

        rx_req   = rx_active && (line_to_rx || host_to_rx);
        tx_req   = tx_active && (line_to_tx || host_to_tx);
        rx_wdata = host_to_rx ? host_wr_data : line_rx_data;
        tx_wdata = host_to_tx ? host_wr_data : line_rx_data;

        rx_pop  = host_rd_en && rx_active && !rx_empty && !rx_flush;
        tx_pop  = tx_ready && !tx_empty && !tx_flush;
        rx_push = rx_req && (!rx_full || rx_pop) && !rx_flush;
        tx_push = tx_req && (!tx_full || tx_pop) && !tx_flush;

        rx_ovr_d = rx_req && rx_full && !rx_pop && !rx_flush;
        tx_ovr_d = tx_req && tx_full && !tx_pop && !tx_flush;
    end

    uart_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push),
        .pop   (rx_pop),
        .wdata (rx_wdata),
        .rdata (rx_head),
        .count (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .pop   (tx_pop),
        .wdata (tx_wdata),
        .rdata (tx_head),
        .count (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uart_rx_timeout #(.TICK_W(TICK_W), .TMO_W(TMO_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_push    (rx_push),
        .rx_flush   (rx_flush),
        .restart    (tmo_restart),
        .tmo_val    (tmo_val),
        .baud_tick  (baud_tick),
        .char_ticks (char_ticks),
        .evt_tmo    (evt_rx_tmo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_rx_ovr <= 1'b0;
            evt_tx_ovr <= 1'b0;
        end else begin
            evt_rx_ovr <= rx_ovr_d;
            evt_tx_ovr <= tx_ovr_d;
        end
    end

    always_comb begin
        host_rd_data = (rx_active && !rx_empty) ? rx_head : '0;
        tx_valid     = !tx_empty;
        tx_data      = tx_head;
    end

endmodule

// File: rtl/uart_chan_ctrl_chk.sv
module uart_chan_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int LVL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr_en,
    input logic [1:0]        ctl_wr_low,
    input logic [8:0]        ctl_rd_data,
    input logic              host_rd_en,
    input logic [DATA_W-1:0] host_rd_data,
    input logic [LVL_W-1:0]  rx_level,
    input logic [LVL_W-1:0]  tx_level,
    input logic              tx_valid,
    input logic              break_req,
    input logic              evt_rx_ovr,
    input logic              evt_tx_ovr,
    input logic              evt_rx_tmo
);

    // R2
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wr_low[0]) |=> (rx_level == '0));

    // R2
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wr_low[1]) |=> (tx_level == '0));

    // R3
    rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctl_rd_data[2] && !ctl_rd_data[3]) && !(ctl_wr_en && ctl_wr_low[0]))
        |=> $stable(rx_level));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH)));

    // R6
    rx_ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_ovr |-> ($past(rx_level) == LVL_W'(DEPTH)) && (rx_level == LVL_W'(DEPTH)));

    // R7
    tx_ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_ovr |-> ($past(tx_level) == LVL_W'(DEPTH)));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> (host_rd_data == '0));

    // R9
    break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_req == (ctl_rd_data[7] && !ctl_rd_data[8]));

    // R10
    tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_tmo |=> !evt_rx_tmo);

    // R12
    tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid == (tx_level != '0));

    // R3
    rx_hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !(ctl_rd_data[2] && !ctl_rd_data[3])) |-> (host_rd_data == '0));

endmodule

bind uart_chan_ctrl uart_chan_ctrl_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .LVL_W  (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr_en    (ctl_wr_en),
    .ctl_wr_low   (ctl_wr_data[1:0]),
    .ctl_rd_data  (ctl_rd_data),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .rx_level     (rx_level),
    .tx_level     (tx_level),
    .tx_valid     (tx_valid),
    .break_req    (break_req),
    .evt_rx_ovr   (evt_rx_ovr),
    .evt_tx_ovr   (evt_tx_ovr),
    .evt_rx_tmo   (evt_rx_tmo)
);

// File: tb/uart_chan_ctrl_tb.sv
module uart_chan_ctrl_tb;

    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [8:0] ctl_wr_data = '0;
    logic [8:0] ctl_rd_data;
    logic       mode_wr_en = 1'b0;
    logic [1:0] mode_wr_field = '0;
    logic [7:0] tmo_val = '0;
    logic [7:0] char_ticks = 8'd2;
    logic       baud_tick = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic       host_rd_en = 1'b0;
    logic [7:0] host_rd_data;
    logic       line_rx_valid = 1'b0;
    logic [7:0] line_rx_data = '0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       break_req;
    logic [LVL_W-1:0] rx_level, tx_level;
    logic       evt_rx_ovr, evt_tx_ovr, evt_rx_tmo;

    int n_chk = 0;
    int n_fail = 0;
    int n_tmo = 0;
    logic [7:0] exp_q [$];
    logic [1:0] mode_m = 2'd0;
    bit         tx_on_m = 1'b0;

    always #2 clk = ~clk;

    uart_chan_ctrl #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .mode_wr_en(mode_wr_en), .mode_wr_field(mode_wr_field),
        .tmo_val(tmo_val), .char_ticks(char_ticks), .baud_tick(baud_tick),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .break_req(break_req), .rx_level(rx_level), .tx_level(tx_level),
        .evt_rx_ovr(evt_rx_ovr), .evt_tx_ovr(evt_tx_ovr), .evt_rx_tmo(evt_rx_tmo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // monitor: pops the scoreboard on each transmit handshake
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected tx byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
            end else begin
                chk("R12 tx order", {24'd0, tx_data}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && evt_rx_tmo) n_tmo <= n_tmo + 1;
    end

    task automatic wr_ctl(input logic [8:0] v);
        ctl_wr_en = 1'b1;
        ctl_wr_data = v;
        step();
        ctl_wr_en = 1'b0;
        tx_on_m = v[4] && !v[5];
        if (v[1]) exp_q.delete();
    endtask

    task automatic wr_mode(input logic [1:0] m);
        mode_wr_en = 1'b1;
        mode_wr_field = m;
        step();
        mode_wr_en = 1'b0;
        mode_m = m;
    endtask

    // driver: expected transmit bytes go into the scoreboard queue
    task automatic line_byte(input logic [7:0] d);
        line_rx_valid = 1'b1;
        line_rx_data = d;
        if (tx_on_m && (mode_m == 2'd1 || mode_m == 2'd3) && exp_q.size() < DEPTH)
            exp_q.push_back(d);
        step();
        line_rx_valid = 1'b0;
    endtask

    task automatic host_byte(input logic [7:0] d);
        host_wr_en = 1'b1;
        host_wr_data = d;
        if (tx_on_m && mode_m == 2'd0 && exp_q.size() < DEPTH)
            exp_q.push_back(d);
        step();
        host_wr_en = 1'b0;
    endtask

    task automatic rd_byte(input string req, input logic [7:0] exp);
        host_rd_en = 1'b1;
        #1;
        chk(req, {24'd0, host_rd_data}, {24'd0, exp});
        step();
        host_rd_en = 1'b0;
    endtask

    task automatic drain();
        tx_ready = 1'b1;
        for (int i = 0; i < 4 * DEPTH && exp_q.size() != 0; i++) step();
        tx_ready = 1'b0;
        step();
        chk("R12 tx drained", {27'd0, tx_level}, 32'd0);
        chk("R12 scoreboard empty", exp_q.size(), 32'd0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1;
            step();
            baud_tick = 1'b0;
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int c0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 ctl reset", {23'd0, ctl_rd_data}, 32'h128);
        chk("R1 rx empty", {27'd0, rx_level}, 32'd0);
        chk("R1 tx empty", {27'd0, tx_level}, 32'd0);
        chk("R9 no break at reset", {31'd0, break_req}, 32'd0);

        // R3 inactive paths ignore traffic
        host_byte(8'h11);
        line_byte(8'h22);
        chk("R3 tx ignored", {27'd0, tx_level}, 32'd0);
        chk("R3 rx ignored", {27'd0, rx_level}, 32'd0);

        wr_ctl(9'h114);
        chk("R1 ctl readback", {23'd0, ctl_rd_data}, 32'h114);

        // R9 break pair
        wr_ctl(9'h094);
        chk("R9 break on", {31'd0, break_req}, 32'd1);
        wr_ctl(9'h194);
        chk("R9 stop wins", {31'd0, break_req}, 32'd0);
        wr_ctl(9'h114);

        // normal mode
        host_byte(8'hA1);
        host_byte(8'hA2);
        chk("R5 normal host to tx", {27'd0, tx_level}, 32'd2);
        line_byte(8'h55);
        chk("R4 normal line to rx", {27'd0, rx_level}, 32'd1);
        chk("R4 normal line not tx", {27'd0, tx_level}, 32'd2);
        rd_byte("R12 rx head", 8'h55);
        rd_byte("R8 empty read", 8'h00);
        drain();

        // echo mode
        wr_mode(2'd1);
        line_byte(8'h3C);
        chk("R4 echo rx", {27'd0, rx_level}, 32'd1);
        chk("R4 echo tx", {27'd0, tx_level}, 32'd1);
        host_byte(8'h77);
        chk("R5 echo host dropped tx", {27'd0, tx_level}, 32'd1);
        chk("R5 echo host dropped rx", {27'd0, rx_level}, 32'd1);
        rd_byte("R4 echo rx byte", 8'h3C);
        drain();

        // local loopback
        wr_mode(2'd2);
        host_byte(8'h42);
        chk("R5 local host to rx", {27'd0, rx_level}, 32'd1);
        chk("R5 local host not tx", {27'd0, tx_level}, 32'd0);
        line_byte(8'h43);
        chk("R4 local line dropped", {27'd0, rx_level}, 32'd1);
        rd_byte("R5 local byte", 8'h42);

        // remote loopback
        wr_mode(2'd3);
        line_byte(8'h9E);
        chk("R4 remote line to tx", {27'd0, tx_level}, 32'd1);
        chk("R4 remote line not rx", {27'd0, rx_level}, 32'd0);
        host_byte(8'h66);
        chk("R5 remote host dropped", {27'd0, tx_level}, 32'd1);
        drain();

        // R3 read gated while rx disabled
        wr_mode(2'd0);
        line_byte(8'h5A);
        wr_ctl(9'h11C);
        rd_byte("R3 disabled read", 8'h00);
        chk("R3 disabled read keeps level", {27'd0, rx_level}, 32'd1);
        wr_ctl(9'h115);

        // R6 full receive queue
        for (int i = 0; i < DEPTH; i++) line_byte(8'h10 + 8'(i));
        chk("R6 rx full", {27'd0, rx_level}, DEPTH);
        line_byte(8'hDD);
        chk("R6 overrun pulse", {31'd0, evt_rx_ovr}, 32'd1);
        chk("R6 overrun level", {27'd0, rx_level}, DEPTH);
        step();
        chk("R6 overrun one cycle", {31'd0, evt_rx_ovr}, 32'd0);
        line_rx_valid = 1'b1;
        line_rx_data = 8'hEE;
        host_rd_en = 1'b1;
        #1;
        chk("R6 same-cycle read data", {24'd0, host_rd_data}, 32'h10);
        step();
        line_rx_valid = 1'b0;
        host_rd_en = 1'b0;
        chk("R6 same-cycle no overrun", {31'd0, evt_rx_ovr}, 32'd0);
        chk("R6 same-cycle level", {27'd0, rx_level}, DEPTH);
        for (int i = 1; i < DEPTH; i++) rd_byte("R12 rx order", 8'h10 + 8'(i));
        rd_byte("R6 late byte last", 8'hEE);

        // R2 flushes
        line_byte(8'h01);
        line_byte(8'h02);
        wr_ctl(9'h115);
        chk("R2 rx flushed", {27'd0, rx_level}, 32'd0);
        chk("R2 reset bits read 0", {23'd0, ctl_rd_data}, 32'h114);
        host_byte(8'h03);
        host_byte(8'h04);
        wr_ctl(9'h116);
        chk("R2 tx flushed", {27'd0, tx_level}, 32'd0);

        // R7 full transmit queue
        for (int i = 0; i < DEPTH; i++) host_byte(8'h80 + 8'(i));
        host_byte(8'hFE);
        chk("R7 overflow pulse", {31'd0, evt_tx_ovr}, 32'd1);
        chk("R7 level held", {27'd0, tx_level}, DEPTH);
        drain();

        // R10 / R11 receive timeout, limit = 4 * 2 = 8 ticks
        wr_ctl(9'h115);
        tmo_val = 8'd1;
        char_ticks = 8'd2;
        c0 = n_tmo;
        line_byte(8'hC1);
        ticks(7);
        chk("R10 no early timeout", n_tmo, c0);
        line_byte(8'hC2);
        ticks(7);
        chk("R11 new byte restarts", n_tmo, c0);
        ticks(1);
        step();
        chk("R10 timeout fires", n_tmo, c0 + 1);
        ticks(10);
        chk("R10 fires once", n_tmo, c0 + 1);
        line_byte(8'hC3);
        ticks(6);
        wr_ctl(9'h154);
        ticks(7);
        chk("R11 restart bit", n_tmo, c0 + 1);
        ticks(1);
        step();
        chk("R11 fires after restart", n_tmo, c0 + 2);
        wr_ctl(9'h114);
        tmo_val = 8'd0;
        line_byte(8'hC4);
        ticks(12);
        chk("R10 disabled timeout", n_tmo, c0 + 2);

        summary();
        $finish;
    end

endmodule